// File: doc/BRIEF.md
# Round-Robin In-Order Cell Multiplexor

This block drives one output line of a switch built from several parallel switching planes. Each plane keeps an output queue for this output line. The block itself holds no cell buffer. During each internal cell slot it walks through the planes in ascending order, always starting at plane 0, and passes the head cell of each plane's queue straight to a single outgoing cell stream. It emits one cell per output-line cycle, so up to K cells leave during one slot. The upstream dispatch discipline places the oldest cell of a flow in plane 0 and the following cells in the consecutive planes. Reading the planes in that order therefore keeps the cells of each flow in sequence. No timestamps, sorting or resequencing memory are involved.

A slot begins when the scheduler offers a slot command on a valid/ready handshake. If the command's shorten flag is clear, the block reads all K planes. If the flag is set, it reads only planes 0 to p-1, where p is the count that comes with the command. A count outside 1 to K-1 is a protocol error, and the block then reads all K planes. A plane whose queue is empty when its turn comes is also a protocol error. That plane's turn is skipped.

The slot command and each plane queue use valid/ready. The block accepts a command only while it is idle. A held command waits until the current sequence has ended and one idle cycle has passed. The outgoing stream is valid/ready as well. While out_ready is low, the block stays on the current plane and withholds that plane's ready. Each plane's ready is the outgoing ready gated combinationally, so a cell passes through without a register.

Top module: `cell_rr_mux`

## Requirements
- R1: After reset, slot_ready is 1, out_valid is 0, err is 0, and every bit of pl_ready is 0.
- R2: Each accepted slot first reads plane 0, in the cycle after the slot handshake (slot_valid and slot_ready both high at a rising edge).
- R3: With slot_req low, the block reads planes 0, 1, ..., K-1 in ascending order, one plane per cycle when nothing stalls, and then returns to idle (slot_ready high) in the next cycle.
- R4: With slot_req high and 1 <= slot_p <= K-1, only planes 0 to slot_p-1 are read. No cell is taken from the higher planes, and the block is idle in the cycle after plane slot_p-1 is read.
- R5: With slot_req high and slot_p equal to 0 or at least K, err is 1 in the handshake cycle, and the slot reads all K planes.
- R6: When the plane due to be read has pl_valid low, err is 1 and out_valid is 0 for that one cycle, and the next cycle moves on to the next plane (or to idle if it was the last).
- R7: While out_valid is 1 and out_ready is 0, the block stays on the same plane and keeps every pl_ready bit at 0.
- R8: slot_ready is 0 while a sequence is running. A slot_valid held high during that time neither alters the sequence nor starts a new one.
- R9: While a cell is offered, out_data equals pl_data of the current plane and out_plane gives that plane's index. pl_ready is 1 only for that plane, and only when out_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-line clock, one cell per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | Scheduler offers a slot command |
| slot_ready | output | 1 | Block is idle and takes the command |
| slot_req | input | 1 | Shorten flag: read only slot_p planes |
| slot_p | input | $clog2(K)+1 | Number of planes to read when slot_req is set |
| pl_valid | input | K | Per-plane head cell present |
| pl_data | input | K*W | Per-plane head cell, plane i in bits [i*W +: W] |
| pl_ready | output | K | Per-plane pop of the head cell |
| out_valid | output | 1 | Outgoing cell present |
| out_ready | input | 1 | Downstream takes the outgoing cell |
| out_data | output | W | Outgoing cell |
| out_plane | output | $clog2(K) | Plane index of the outgoing cell |
| err | output | 1 | Protocol-error pulse (bad count or empty plane) |

## Verification
Assertions run on every cycle and check these properties: each sequence restarts at plane 0, the plane index moves by exactly one per step, the index holds under back-pressure, at most one plane is popped at a time, and no cell or plane pop appears outside a running sequence. Only the directed scenarios can show the following: the exact plane order and cell contents for each slot length, a shortened slot leaving the higher planes untouched, the fallback to a full read on a bad count, the skip over an empty plane, and a held command being ignored until the block is idle.

// File: rtl/cell_rr_mux_pkg.sv
package cell_rr_mux_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cell_rr_plane_sel.sv
module cell_rr_plane_sel #(
  parameter int K  = 4,
  parameter int W  = 16,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic [IW-1:0]  sel,
  input  logic [K-1:0]   pl_valid,
  input  logic [K*W-1:0] pl_data,
  input  logic           grant,
  output logic           head_valid,
  output logic [W-1:0]   head_data,
  output logic [K-1:0]   pop
);
  logic [W-1:0] lane [K];

  for (genvar g = 0; g < K; g++) begin : g_lane
    assign lane[g] = pl_data[g*W +: W];
    assign pop[g]  = grant && (sel == IW'(g)) && pl_valid[g];
  end

  assign head_valid = pl_valid[sel];
  assign head_data  = lane[sel];

  always_comb begin
    assert ($onehot0(pop)) else $error("p_single_pop_r9");
  end
endmodule

// File: rtl/cell_rr_slot_ctrl.sv
module cell_rr_slot_ctrl
  import cell_rr_mux_pkg::*;
#(
  parameter int K  = 4,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int PW = $clog2(K) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  input  logic          slot_req,
  input  logic [PW-1:0] slot_p,
  input  logic          advance,
  output logic          slot_ready,
  output logic          running,
  output logic [IW-1:0] idx,
  output logic          bad_count
);
  seq_state_e    state;
  logic [IW-1:0] limit;
  logic          take;
  logic          count_ok;
  logic [IW-1:0] limit_next;

  assign running    = (state == SEQ_RUN);
  assign slot_ready = !running;
  assign take       = slot_valid && slot_ready;
  assign count_ok   = (slot_p != '0) && (slot_p < PW'(K));
  assign limit_next = (slot_req && count_ok) ? IW'(slot_p - 1'b1) : IW'(K - 1);
  assign bad_count  = take && slot_req && !count_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      idx   <= '0;
      limit <= '0;
    end else if (take) begin
      state <= SEQ_RUN;
      idx   <= '0;
      limit <= limit_next;
    end else if (running && advance) begin
      if (idx == limit) begin
        state <= SEQ_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_start_plane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_ready) |=> (running && idx == '0));
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && advance && $past(running)) |=> (!running || idx == $past(idx) + 1'b1));
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !advance) |=> (running && $stable(idx)));
  p_busy_blocks_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(advance && idx == limit)) |=> !slot_ready);
endmodule

// File: rtl/cell_rr_mux.sv
module cell_rr_mux #(
  parameter int K  = 4,
  parameter int W  = 16,
  localparam int IW = (K > 1) ? $clog2(K) : 1,
  localparam int PW = $clog2(K) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  output logic          slot_ready,
  input  logic          slot_req,
  input  logic [PW-1:0] slot_p,
  input  logic [K-1:0]  pl_valid,
  input  logic [K*W-1:0] pl_data,
  output logic [K-1:0]  pl_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [IW-1:0] out_plane,
  output logic          err
);
  logic          running;
  logic [IW-1:0] idx;
  logic          bad_count;
  logic          head_valid;
  logic [W-1:0]  head_data;
  logic          advance;
  logic          grant;

  cell_rr_slot_ctrl #(.K(K)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (slot_valid),
    .slot_req   (slot_req),
    .slot_p     (slot_p),
    .advance    (advance),
    .slot_ready (slot_ready),
    .running    (running),
    .idx        (idx),
    .bad_count  (bad_count)
  );

  assign grant = running && out_ready;

  cell_rr_plane_sel #(.K(K), .W(W)) u_sel (
    .sel        (idx),
    .pl_valid   (pl_valid),
    .pl_data    (pl_data),
    .grant      (grant),
    .head_valid (head_valid),
    .head_data  (head_data),
    .pop        (pl_ready)
  );

  assign advance   = running && (!head_valid || out_ready);
  assign out_valid = running && head_valid;
  assign out_data  = head_data;
  assign out_plane = idx;
  assign err       = bad_count || (running && !head_valid);

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!out_valid && pl_ready == '0));
  p_no_pop_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (pl_ready == '0));
  p_pop_matches_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> $countones(pl_ready) == 1);
endmodule

// File: tb/test_cell_rr_mux.sv
module test_cell_rr_mux;
  localparam int K  = 4;
  localparam int W  = 16;
  localparam int IW = $clog2(K);
  localparam int PW = $clog2(K) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_valid = 1'b0;
  logic          slot_ready;
  logic          slot_req = 1'b0;
  logic [PW-1:0] slot_p = '0;
  logic [K-1:0]  pl_valid = '1;
  logic [K*W-1:0] pl_data;
  logic [K-1:0]  pl_ready;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_data;
  logic [IW-1:0] out_plane;
  logic          err;

  logic [7:0] cnt [K];
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cell_rr_mux #(.K(K), .W(W)) i_cell_rr_mux (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_req(slot_req), .slot_p(slot_p), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_plane(out_plane), .err(err)
  );

  for (genvar g = 0; g < K; g++) begin : g_q
    assign pl_data[g*W +: W] = {8'(g), cnt[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= 8'h10 * 8'(g + 1);
      else if (pl_valid[g] && pl_ready[g]) cnt[g] <= cnt[g] + 8'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_slot(input bit rq, input int p, input bit exp_err, input string req);
    slot_valid = 1'b1;
    slot_req   = rq;
    slot_p     = PW'(p);
    #1;
    chk(slot_ready == 1'b1, req, slot_ready, 1);
    chk(err == exp_err, req, err, exp_err);
    step();
    slot_valid = 1'b0;
  endtask

  task automatic expect_cell(input int pl, input string req);
    logic [W-1:0] exp_d;
    #1;
    exp_d = {8'(pl), cnt[pl]};
    chk(out_valid == 1'b1, req, out_valid, 1);
    chk(out_plane == IW'(pl), req, out_plane, pl);
    chk(out_data == exp_d, req, out_data, exp_d);
    chk(pl_ready == K'(1 << pl), req, pl_ready, 1 << pl);
    chk(err == 1'b0, req, err, 0);
    step();
  endtask

  task automatic expect_idle(input string req);
    #1;
    chk(slot_ready == 1'b1 && out_valid == 1'b0, req, {slot_ready, out_valid}, 2);
  endtask

  task automatic t_reset();
    #1;
    chk(slot_ready == 1'b1, "R1", slot_ready, 1);
    chk(out_valid == 1'b0 && err == 1'b0, "R1", {out_valid, err}, 0);
    chk(pl_ready == '0, "R1", pl_ready, 0);
  endtask

  task automatic t_full();
    start_slot(1'b0, 2, 1'b0, "R3");
    for (int i = 0; i < K; i++) expect_cell(i, i == 0 ? "R2" : "R3");
    expect_idle("R3");
  endtask

  task automatic t_short(input int p);
    logic [7:0] hi;
    hi = cnt[K-1];
    start_slot(1'b1, p, 1'b0, "R4");
    for (int i = 0; i < p; i++) expect_cell(i, "R4");
    expect_idle("R4");
    chk(cnt[K-1] == hi, "R4", cnt[K-1], hi);
  endtask

  task automatic t_bad(input int p);
    start_slot(1'b1, p, 1'b1, "R5");
    for (int i = 0; i < K; i++) expect_cell(i, "R5");
    expect_idle("R5");
  endtask

  task automatic t_empty();
    logic [7:0] c1;
    pl_valid = 4'b1101;
    c1 = cnt[1];
    start_slot(1'b0, 0, 1'b0, "R6");
    expect_cell(0, "R6");
    #1;
    chk(err == 1'b1 && out_valid == 1'b0, "R6", {err, out_valid}, 2);
    chk(pl_ready == '0, "R6", pl_ready, 0);
    step();
    expect_cell(2, "R6");
    expect_cell(3, "R6");
    expect_idle("R6");
    chk(cnt[1] == c1, "R6", cnt[1], c1);
    pl_valid = '1;
  endtask

  task automatic t_stall();
    start_slot(1'b0, 0, 1'b0, "R7");
    out_ready = 1'b0;
    for (int s = 0; s < 2; s++) begin
      #1;
      chk(out_valid == 1'b1 && out_plane == '0, "R7", out_plane, 0);
      chk(pl_ready == '0, "R7", pl_ready, 0);
      step();
    end
    out_ready = 1'b1;
    for (int i = 0; i < K; i++) expect_cell(i, "R7");
    expect_idle("R7");
  endtask

  task automatic t_held_cmd();
    start_slot(1'b0, 0, 1'b0, "R8");
    slot_valid = 1'b1;
    slot_req   = 1'b1;
    slot_p     = PW'(1);
    for (int i = 0; i < K; i++) begin
      #1;
      chk(slot_ready == 1'b0, "R8", slot_ready, 0);
      if (i == K - 1) begin
        expect_cell(i, "R8");
        slot_valid = 1'b0;
      end else begin
        expect_cell(i, "R8");
      end
    end
    expect_idle("R8");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_full();
        t_short(2);
        t_short(1);
        t_short(3);
        t_bad(0);
        t_bad(4);
        t_empty();
        t_stall();
        t_held_cmd();
        t_full();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule